// File: doc/BRIEF.md
# Shared Receive Silo with Alarm

This block is the common receive queue of a four-line asynchronous multiplexer. Each line's receiver hands over a finished character with its line number and its framing and parity error flags. The silo stores these in arrival order and gives the host one word at a time through a single read strobe. A receive-done flag shows that a word is waiting at the output. After each pop the flag stays low for a short settling interval while the next entry moves up.

An optional alarm lets software service the queue in bursts instead of once per character. When the alarm is enabled it rises once a set number of characters has been queued since the last pop. It then replaces the done flag as the source of the receive interrupt. Software drains the silo by reading until a word comes back with its top bit clear. A character that arrives while the silo is full is lost, and the next character that is stored carries an overrun mark.

Top module: `rx_silo`

## Requirements
- R1: A push accepted into an empty silo, with no settling interval running, makes `done` high and presents the entry on `rd_word` from the next clock edge.
- R2: `rd_word` is {bit15 valid, bit14 overrun, bit13 framing error, bit12 parity error, bits11:10 zero, bits9:8 line, bits7:0 data}. While `done` is low the whole word reads as zero, so bit15 is zero.
- R3: A `rd` pulse while `done` is high pops the head entry. `done` then stays low for SETTLE cycles (default 4) and rises on the edge after that if an entry remains.
- R4: A `rd` pulse while `done` is low changes nothing. No entry is lost, and the next word read is still the oldest one stored.
- R5: With `alarm_en` high, `alarm` rises on the edge that accepts the ALARM_AT-th entry (default 16) since reset or the last pop.
- R6: A pop clears `alarm`. It rises again only after ALARM_AT further accepted entries.
- R7: `alarm` is low whenever `alarm_en` is low.
- R8: `irq` equals `rx_ie` AND (`alarm` when `alarm_en` is high, otherwise `done`). So with the alarm enabled, a waiting character alone raises no interrupt.
- R9: The silo holds DEPTH entries (default 64). A push while full is dropped, and the next accepted entry has its overrun bit (bit14) set.
- R10: While `scan_en` is low, `done`, `alarm` and `irq` are low, the silo is emptied and pushes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_en | input | 1 | Master enable; low flushes the silo |
| alarm_en | input | 1 | Enables the burst alarm |
| rx_ie | input | 1 | Receive interrupt enable |
| push | input | 1 | Character ready from a line receiver |
| push_line | input | 2 | Line number of the character |
| push_data | input | 8 | Character data |
| push_ferr | input | 1 | Framing error of the character |
| push_perr | input | 1 | Parity error of the character |
| rd | input | 1 | Host read strobe; pops one entry when done is high |
| rd_word | output | 16 | Head entry in read-word format |
| done | output | 1 | A word is ready at the output |
| alarm | output | 1 | Alarm threshold reached since last pop |
| irq | output | 1 | Receive interrupt request |

## Verification
A push and its stored word are due on the first clock edge after the push is sampled. The alarm rises on that same edge. The bench drives on falling edges and samples on the following falling edge, so each result is read half a cycle after the edge that produced it. After a pop, `done` is sampled at each of the next falling edges: low for exactly SETTLE of them and high at the next. Stray read pulses are placed inside that window. `alarm`, `irq` and the flushing effect of `scan_en` are checked one falling edge after their control inputs change.

// File: rtl/rx_silo.sv
module rx_silo #(
  parameter int DEPTH    = 64,
  parameter int ALARM_AT = 16,
  parameter int SETTLE   = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int SW = $clog2(SETTLE + 2),
  localparam int KW = $clog2(ALARM_AT + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scan_en,
  input  logic        alarm_en,
  input  logic        rx_ie,
  input  logic        push,
  input  logic [1:0]  push_line,
  input  logic [7:0]  push_data,
  input  logic        push_ferr,
  input  logic        push_perr,
  input  logic        rd,
  output logic [15:0] rd_word,
  output logic        done,
  output logic        alarm,
  output logic        irq
);

  logic [12:0]   mem [DEPTH];
  logic [AW-1:0] rptr, wptr;
  logic [CW-1:0] count;
  logic [SW-1:0] settle;
  logic [KW-1:0] acnt;
  logic          ovr_pend;
  logic          empty, full, pop, acc, drop;
  logic [12:0]   head;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign done  = scan_en && !empty && (settle == '0);
  assign pop   = rd && done;
  assign acc   = push && scan_en && (!full || pop);
  assign drop  = push && scan_en && full && !pop;
  assign head  = mem[rptr];

  assign rd_word = done ? {1'b1, head[12:10], 2'b00, head[9:0]} : 16'h0000;
  assign alarm   = alarm_en && (acnt == KW'(ALARM_AT));
  assign irq     = rx_ie && (alarm_en ? alarm : done);

  always_ff @(posedge clk) begin
    if (acc) mem[wptr] <= {ovr_pend, push_ferr, push_perr, push_line, push_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr     <= '0;
      wptr     <= '0;
      count    <= '0;
      settle   <= '0;
      acnt     <= '0;
      ovr_pend <= 1'b0;
    end else if (!scan_en) begin
      rptr     <= '0;
      wptr     <= '0;
      count    <= '0;
      settle   <= '0;
      acnt     <= '0;
      ovr_pend <= 1'b0;
    end else begin
      if (acc) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({acc, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (pop)                 settle <= SW'(SETTLE);
      else if (settle != '0)   settle <= settle - 1'b1;
      if (pop)                 acnt <= acc ? KW'(1) : '0;
      else if (acc && acnt != KW'(ALARM_AT)) acnt <= acnt + 1'b1;
      if (acc)       ovr_pend <= 1'b0;
      else if (drop) ovr_pend <= 1'b1;
    end
  end

  // R1: a character entering an idle empty silo is ready one edge later
  a_r1_push_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && empty && settle == '0 && !pop) |=> (done || !scan_en));

  // R3: a pop always opens a settling gap
  a_r3_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !done);

  // R5: once raised, the alarm persists until a pop or disable
  a_r5_alarm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !pop && scan_en) |=> (alarm || !alarm_en || !scan_en));

  // R6: a pop clears the alarm
  a_r6_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !alarm);

  // R9: occupancy never exceeds depth
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

endmodule

// File: tb/rx_silo_bench.sv
`timescale 1ns/1ps
module rx_silo_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_en = 1'b0, alarm_en = 1'b0, rx_ie = 1'b0;
  logic push = 1'b0, rd = 1'b0, push_ferr = 1'b0, push_perr = 1'b0;
  logic [1:0] push_line = '0;
  logic [7:0] push_data = '0;
  logic [15:0] rd_word;
  logic done, alarm, irq;

  int checks = 0, errors = 0;
  int mcount = 0;
  bit mpend = 1'b0;
  logic [15:0] exp_q[$];

  always #2.5 clk = ~clk;

  rx_silo u_rx_silo (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .alarm_en(alarm_en), .rx_ie(rx_ie),
    .push(push), .push_line(push_line), .push_data(push_data),
    .push_ferr(push_ferr), .push_perr(push_perr), .rd(rd),
    .rd_word(rd_word), .done(done), .alarm(alarm), .irq(irq));

  task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: issues a push and records the word the silo should hand back
  task automatic drive(logic [1:0] ln, logic [7:0] d, bit fe, bit pe);
    push = 1'b1; push_line = ln; push_data = d; push_ferr = fe; push_perr = pe;
    @(negedge clk);
    push = 1'b0;
    if (scan_en) begin
      if (mcount == 64) mpend = 1'b1;
      else begin
        exp_q.push_back({1'b1, mpend, fe, pe, 2'b00, ln, d});
        mpend = 1'b0;
        mcount++;
      end
    end
  endtask

  // monitor: waits for a ready word, compares with the queue head, pops it
  task automatic take();
    logic [15:0] e;
    int n = 0;
    while (!done && n < 20) begin @(negedge clk); n++; end
    e = exp_q.pop_front();
    chk(done == 1'b1, "R3 done after settle", {15'd0, done}, 16'd1);
    chk(rd_word == e, e[14] ? "R9 overrun word" : "R2 word", rd_word, e);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    mcount--;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !alarm && !irq && rd_word == 16'h0, "R2 reset", rd_word, 16'h0);
    scan_en = 1'b1; rx_ie = 1'b1;
    @(negedge clk);

    drive(2'd1, 8'hA5, 1'b1, 1'b0);
    chk(done == 1'b1, "R1 done next edge", {15'd0, done}, 16'd1);
    chk(rd_word == 16'h81A5 + 16'h2000, "R2 layout", rd_word, 16'hA1A5);
    chk(irq == 1'b1, "R8 irq from done", {15'd0, irq}, 16'd1);
    drive(2'd3, 8'h3C, 1'b0, 1'b1);
    take();
    chk(done == 1'b0, "R3 low after pop", {15'd0, done}, 16'd0);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk(done == 1'b0, "R3 settle 1", {15'd0, done}, 16'd0);
    @(negedge clk);
    chk(done == 1'b0, "R3 settle 2", {15'd0, done}, 16'd0);
    @(negedge clk);
    chk(done == 1'b0, "R3 settle 3", {15'd0, done}, 16'd0);
    @(negedge clk);
    chk(done == 1'b1, "R3 done after 4", {15'd0, done}, 16'd1);
    chk(rd_word == exp_q[0], "R4 stray read ignored", rd_word, exp_q[0]);
    take();
    repeat (5) @(negedge clk);
    chk(!done && rd_word == 16'h0, "R2 empty word bit15 clear", rd_word, 16'h0);

    alarm_en = 1'b1;
    for (int i = 0; i < 15; i++) drive(2'(i), 8'(i + 16), 1'b0, 1'b0);
    chk(alarm == 1'b0, "R5 no alarm at 15", {15'd0, alarm}, 16'd0);
    chk(irq == 1'b0, "R8 done masked by alarm mode", {15'd0, irq}, 16'd0);
    drive(2'd2, 8'h77, 1'b0, 1'b0);
    chk(alarm == 1'b1, "R5 alarm at 16", {15'd0, alarm}, 16'd1);
    chk(irq == 1'b1, "R8 irq from alarm", {15'd0, irq}, 16'd1);
    take();
    chk(alarm == 1'b0, "R6 pop clears alarm", {15'd0, alarm}, 16'd0);
    for (int i = 0; i < 15; i++) drive(2'(i + 1), 8'(i + 64), 1'b1, 1'b1);
    chk(alarm == 1'b0, "R6 no re-arm at 15", {15'd0, alarm}, 16'd0);
    drive(2'd0, 8'hEE, 1'b0, 1'b0);
    chk(alarm == 1'b1, "R6 re-arm at 16", {15'd0, alarm}, 16'd1);
    alarm_en = 1'b0;
    @(negedge clk);
    chk(alarm == 1'b0, "R7 alarm gated", {15'd0, alarm}, 16'd0);
    while (mcount > 0) take();

    for (int i = 0; i < 66; i++) drive(2'(i), 8'(i + 100), 1'b0, 1'b0);
    take();
    drive(2'd3, 8'h5A, 1'b0, 1'b0);
    chk(exp_q[63][14] == 1'b1, "R9 model marks overrun", {15'd0, exp_q[63][14]}, 16'd1);
    while (mcount > 0) take();

    repeat (5) @(negedge clk);
    for (int i = 0; i < 3; i++) drive(2'(i), 8'(i + 200), 1'b0, 1'b0);
    scan_en = 1'b0;
    @(negedge clk);
    chk(!done && !irq && rd_word == 16'h0, "R10 scan off", rd_word, 16'h0);
    drive(2'd1, 8'h99, 1'b0, 1'b0);
    scan_en = 1'b1;
    @(negedge clk);
    chk(!done && rd_word == 16'h0, "R10 flushed and ignored", rd_word, 16'h0);
    exp_q.delete();
    mcount = 0;
    mpend = 1'b0;
    drive(2'd2, 8'h42, 1'b0, 1'b0);
    take();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule